// File: doc/BRIEF.md
# Ethernet Controller Control and Status Register Block

This block is the slave-side register file of an Ethernet controller. It holds a set of 16-bit control and status registers behind a bus port that is always 32 bits wide. The register index is taken from the byte address shifted right by a fixed amount. Each register applies its own rule on write: some writes are gated by the controller's reset state, some bits are forced to zero, some registers clear bits by writing ones, and the error tallies keep the complement of what was written.

The receive and transmit logic raises status bits through a dedicated input. Status is combined with the interrupt mask to drive one interrupt line. A strobe is raised when software clears the receive-buffers-exhausted status, so that the descriptor logic can fetch the next receive resource. A byte-order input selects the bus half that carries register data: the lower half in little-endian mode and the upper half in big-endian mode.

Top module: `eth_csr_block`

## Requirements
- R1: After reset all stored registers read 0x0000, except the command register (index 0), which reads 0x0080 with the halt bit (bit 7) set. The irq output and the fetch strobe are low.
- R2: With big_endian low, write data is taken from bits 15:0 and read data is returned in bits 15:0 with bits 31:16 zero. With big_endian high, write data is taken from bits 31:16 and read data is returned in bits 31:16 with bits 15:0 zero. The other half of the write word is ignored.
- R3: The configuration register (index 1, mask 0xBFFF) and the second configuration register (index 2, mask 0xF017) accept a write only while command bit 7 is set. Otherwise the write is ignored.
- R4: The transmit-control register (index 3) stores write data AND 0xF000. The receive-control register (index 4) stores write data AND 0xFFE0.
- R5: The interrupt-mask register (index 5) stores write data AND 0x7FFF.
- R6: Writing the interrupt-status register (index 6) clears each bit that is both set and written as 1. All other bits are kept.
- R7: A 1 on bit n of stat_set sets status bit n on the next clock edge. When a set and a clear hit the same bit in the same cycle, the set wins.
- R8: irq is high exactly when (status AND mask) is nonzero, and it follows status or mask changes on the same clock edge that updates them.
- R9: desc_fetch_req is high for one cycle, right after the edge at which a status write with bit 5 (buffers exhausted) set finds status bit 5 set. It stays low when that bit was already clear.
- R10: The ring start, ring end, read pointer and write pointer registers (indices 7 to 10) store write data AND 0xFFFE.
- R11: The CRC, alignment and missed-packet tally registers (indices 11 to 13) store the bitwise inverse of write data.
- R12: The capability registers (indices 14 and 15) read the CAP0_VAL and CAP1_VAL parameters (defaults 0x5A01 and 0x0003), and writes to them are ignored. The general registers (indices 16 and 17) store data unchanged. Indices 18 and above read 0x0000, and writes to them are ignored.
- R13: The register index is addr shifted right by IDX_SHIFT (default 2), so the low address bits are ignored. A read asserted in one cycle returns rd_data with rd_valid in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| big_endian | input | 1 | Selects the upper half of the data word for register data |
| addr | input | IDX_W+IDX_SHIFT | Byte address of the access |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data word |
| rd_en | input | 1 | Read strobe |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 32 | Read data word |
| stat_set | input | 16 | Per-bit status set requests from the MAC side |
| irq | output | 1 | Interrupt request |
| desc_fetch_req | output | 1 | One-cycle request to fetch the next receive resource |

## Verification
Hardware status setting and software write-one-to-clear can land on the same status bit in the same cycle. The bench provokes this by driving stat_set and a status write together, once on an ordinary bit and once on the buffers-exhausted bit. It then reads status back and expects the bit still set with irq still high. In the second case it also expects the fetch strobe to fire, because the write found the bit set. The lane selection is checked by placing a junk pattern in the unused half of every written word.

// File: rtl/eth_csr_block.sv
module eth_csr_block #(
  parameter int IDX_W     = 5,
  parameter int IDX_SHIFT = 2,
  parameter int HALT_BIT  = 7,
  parameter int EXH_BIT   = 5,
  parameter logic [15:0] CAP0_VAL = 16'h5A01,
  parameter logic [15:0] CAP1_VAL = 16'h0003
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       big_endian,
  input  logic [IDX_W+IDX_SHIFT-1:0] addr,
  input  logic                       wr_en,
  input  logic [31:0]                wdata,
  input  logic                       rd_en,
  output logic                       rd_valid,
  output logic [31:0]                rd_data,
  input  logic [15:0]                stat_set,
  output logic                       irq,
  output logic                       desc_fetch_req
);
  localparam int ADDR_W = IDX_W + IDX_SHIFT;
  localparam int NREG   = 18;
  localparam logic [15:0] CMD_RST = 16'h0001 << HALT_BIT;

  localparam logic [IDX_W-1:0] I_CMD  = 0,  I_CFG  = 1,  I_CFG2 = 2,  I_TXC  = 3;
  localparam logic [IDX_W-1:0] I_RXC  = 4,  I_IMSK = 5,  I_ISTA = 6,  I_RSTA = 7;
  localparam logic [IDX_W-1:0] I_REND = 8,  I_RPTR = 9,  I_WPTR = 10, I_TCRC = 11;
  localparam logic [IDX_W-1:0] I_TALN = 12, I_TMIS = 13, I_CAP0 = 14, I_CAP1 = 15;
  localparam logic [IDX_W-1:0] I_GP0  = 16, I_GP1  = 17;

  logic [15:0] rf [NREG];
  logic [IDX_W-1:0] idx;
  logic [15:0] wval, rval, clr, ista_nxt;
  logic halted;

  assign idx      = addr[ADDR_W-1:IDX_SHIFT];
  assign wval     = big_endian ? wdata[31:16] : wdata[15:0];
  assign halted   = rf[I_CMD][HALT_BIT];
  assign clr      = (wr_en && idx == I_ISTA) ? (wval & rf[I_ISTA]) : 16'h0000;
  assign ista_nxt = (rf[I_ISTA] & ~clr) | stat_set;
  assign irq      = |(rf[I_ISTA] & rf[I_IMSK]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= 16'h0000;
      rf[I_CMD]      <= CMD_RST;
      desc_fetch_req <= 1'b0;
    end else begin
      rf[I_ISTA]     <= ista_nxt;
      desc_fetch_req <= clr[EXH_BIT];
      if (wr_en) begin
        case (idx)
          I_CMD:  rf[I_CMD]  <= wval;
          I_CFG:  if (halted) rf[I_CFG]  <= wval & 16'hBFFF;
          I_CFG2: if (halted) rf[I_CFG2] <= wval & 16'hF017;
          I_TXC:  rf[I_TXC]  <= wval & 16'hF000;
          I_RXC:  rf[I_RXC]  <= wval & 16'hFFE0;
          I_IMSK: rf[I_IMSK] <= wval & 16'h7FFF;
          I_RSTA: rf[I_RSTA] <= wval & 16'hFFFE;
          I_REND: rf[I_REND] <= wval & 16'hFFFE;
          I_RPTR: rf[I_RPTR] <= wval & 16'hFFFE;
          I_WPTR: rf[I_WPTR] <= wval & 16'hFFFE;
          I_TCRC: rf[I_TCRC] <= ~wval;
          I_TALN: rf[I_TALN] <= ~wval;
          I_TMIS: rf[I_TMIS] <= ~wval;
          I_GP0:  rf[I_GP0]  <= wval;
          I_GP1:  rf[I_GP1]  <= wval;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (idx)
      I_CAP0: rval = CAP0_VAL;
      I_CAP1: rval = CAP1_VAL;
      default: rval = (idx < IDX_W'(NREG)) ? rf[idx] : 16'h0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= 32'h0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= big_endian ? {rval, 16'h0000} : {16'h0000, rval};
    end
  end

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == I_CFG && !halted) |=> $stable(rf[I_CFG])); // R3
  AST_STAT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    ((rf[I_ISTA] & ~$past(rf[I_ISTA]) & ~$past(stat_set)) == 16'h0000)); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_set != 16'h0000) |=> ((rf[I_ISTA] & $past(stat_set)) == $past(stat_set))); // R7
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (rf[I_IMSK] == 16'h0000) |-> !irq); // R8
  AST_FETCH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    desc_fetch_req |-> ($past(wr_en) && $past(rf[I_ISTA][EXH_BIT]))); // R9
  AST_RD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid); // R13
endmodule

// File: tb/test_eth_csr_block.sv
module test_eth_csr_block;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 5;
  localparam int SH = 2;

  logic clk = 0, rst_n = 0, big_endian = 0, wr_en = 0, rd_en = 0;
  logic [IDX_W+SH-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [15:0] stat_set = '0;
  logic rd_valid, irq, desc_fetch_req;
  logic [31:0] rd_data;

  int checks = 0, fails = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  bit done = 0;

  eth_csr_block i_eth_csr_block (
    .clk(clk), .rst_n(rst_n), .big_endian(big_endian), .addr(addr),
    .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en), .rd_valid(rd_valid),
    .rd_data(rd_data), .stat_set(stat_set), .irq(irq),
    .desc_fetch_req(desc_fetch_req));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) check("R13 unexpected rd_valid", 32'h1, 32'h0);
      else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  task automatic wr_s(int idx, logic [15:0] v, logic [15:0] s);
    addr = (IDX_W+SH)'(idx << SH);
    wdata = big_endian ? {v, 16'hDEAD} : {16'hBEEF, v};
    wr_en = 1; stat_set = s;
    @(negedge clk);
    wr_en = 0; stat_set = 0;
  endtask

  task automatic wr(int idx, logic [15:0] v);
    wr_s(idx, v, 16'h0);
  endtask

  task automatic rd_a(logic [IDX_W+SH-1:0] a, logic [15:0] e, string tag);
    addr = a; rd_en = 1;
    exp_q.push_back(big_endian ? {e, 16'h0} : {16'h0, e});
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic rd(int idx, logic [15:0] e, string tag);
    rd_a((IDX_W+SH)'(idx << SH), e, tag);
  endtask

  task automatic pulse_set(logic [15:0] s);
    stat_set = s;
    @(negedge clk);
    stat_set = 0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 irq after reset", {31'h0, irq}, 32'h0);
    check("R1 fetch strobe after reset", {31'h0, desc_fetch_req}, 32'h0);
    rd(0, 16'h0080, "R1 command reset value");
    rd(1, 16'h0000, "R1 config reset value");
    rd(6, 16'h0000, "R1 status reset value");
    rd(11, 16'h0000, "R1 tally reset value");

    wr(1, 16'hFFFF);  rd(1, 16'hBFFF, "R3 config write while halted");
    wr(2, 16'hFFFF);  rd(2, 16'hF017, "R3 config2 write while halted");
    wr(0, 16'h0000);  rd(0, 16'h0000, "R2 command plain store");
    wr(1, 16'h1234);  rd(1, 16'hBFFF, "R3 config write ignored when running");
    wr(2, 16'h0000);  rd(2, 16'hF017, "R3 config2 write ignored when running");

    wr(3, 16'hFFFF);  rd(3, 16'hF000, "R4 transmit control mask");
    wr(4, 16'hFFFF);  rd(4, 16'hFFE0, "R4 receive control mask");
    wr(5, 16'hFFFF);  rd(5, 16'h7FFF, "R5 interrupt mask msb dropped");

    wr(7, 16'h4321);  rd(7, 16'h4320, "R10 ring start bit0");
    wr(8, 16'h1235);  rd(8, 16'h1234, "R10 ring end bit0");
    wr(9, 16'hFFFF);  rd(9, 16'hFFFE, "R10 read pointer bit0");
    wr(10, 16'h0001); rd(10, 16'h0000, "R10 write pointer bit0");

    wr(11, 16'h00FF); rd(11, 16'hFF00, "R11 crc tally inverted");
    wr(12, 16'hA5A5); rd(12, 16'h5A5A, "R11 align tally inverted");
    wr(13, 16'h0000); rd(13, 16'hFFFF, "R11 missed tally inverted");

    wr(14, 16'h0000); rd(14, 16'h5A01, "R12 capability0 read-only");
    wr(15, 16'hFFFF); rd(15, 16'h0003, "R12 capability1 read-only");
    wr(16, 16'hABCD); rd(16, 16'hABCD, "R12 general register");
    wr(25, 16'hFFFF); rd(25, 16'h0000, "R12 undefined index reads zero");
    rd(17, 16'h0000, "R12 undefined write left general register");
    rd_a(7'((16 << SH) | 3), 16'hABCD, "R13 low address bits ignored");

    pulse_set(16'h0021);
    check("R8 irq on status with mask", {31'h0, irq}, 32'h1);
    rd(6, 16'h0021, "R7 status set by stat_set");
    wr(6, 16'h0001);
    check("R9 no strobe on other bit clear", {31'h0, desc_fetch_req}, 32'h0);
    rd(6, 16'h0020, "R6 write one clears only that bit");
    wr(6, 16'h0020);
    check("R9 strobe on exhausted clear", {31'h0, desc_fetch_req}, 32'h1);
    check("R8 irq drops with status", {31'h0, irq}, 32'h0);
    @(negedge clk);
    check("R9 strobe one cycle", {31'h0, desc_fetch_req}, 32'h0);
    wr(6, 16'h0020);
    check("R9 no strobe when already clear", {31'h0, desc_fetch_req}, 32'h0);

    pulse_set(16'h0040);
    wr_s(6, 16'h0040, 16'h0040);
    check("R7 set wins irq", {31'h0, irq}, 32'h1);
    rd(6, 16'h0040, "R7 set wins over clear");
    pulse_set(16'h0020);
    wr_s(6, 16'h0020, 16'h0020);
    check("R9 strobe with simultaneous set", {31'h0, desc_fetch_req}, 32'h1);
    rd(6, 16'h0060, "R7 exhausted bit kept by set");

    wr(5, 16'h0000);
    check("R8 irq masked off", {31'h0, irq}, 32'h0);
    wr(5, 16'h0040);
    check("R8 irq unmasked", {31'h0, irq}, 32'h1);

    big_endian = 1;
    wr(17, 16'h1357); rd(17, 16'h1357, "R2 big-endian lane");
    rd(16, 16'hABCD, "R2 big-endian read of older value");
    wr(11, 16'h0F0F); rd(11, 16'hF0F0, "R2 big-endian tally write");
    big_endian = 0;
    rd(17, 16'h1357, "R2 little-endian lane again");

    repeat (3) @(negedge clk);
    check("R13 all reads returned", exp_q.size(), 0);
    done = 1;
    finish_run();
  end
endmodule